// File: doc/BRIEF.md
# TDM Serial Channel Interrupt Generator

This block sits inside a multichannel time-division serial port. It follows the serial clock, keeps track of which bit of which channel slot is on the line, and raises one receive event and one transmit event per frame. Each slot carries an 8-bit word, most significant bit first. A frame starts when `frame_sync` is sampled high. The first bit of channel 0 occupies the next serial clock cycle. The channel counter then moves on every 8 serial clocks until the last configured channel has finished.

Events are generated according to the mode. In single-channel mode (`multi_mode` = 0) an event fires one serial clock after the word begins. In multichannel mode it fires one serial clock after the final bit of a software-chosen channel. Receive and transmit each have their own 4-bit select. Each event crosses into the system clock domain by flipping a toggle that a synchroniser follows. The result is a one-cycle interrupt pulse and a sticky status bit, which software clears by writing one.

Top module: `tdm_irq_gen`

## Requirements
- R1: While `rst_n` is low and right after it is released, `irq_rx`, `irq_tx`, `stat_rx` and `stat_tx` are all 0.
- R2: A frame starts at the serial edge E0 that samples `frame_sync` high. Slot c covers serial edges E0+8c+1 through E0+8c+8 (8 bits, MSB first). The frame ends after slot `last_chan`, and no further event occurs until the next frame sync.
- R3: In single-channel mode, each frame raises exactly one receive and one transmit event at serial edge E0+1, whatever the values of `irq_sel` and `last_chan`.
- R4: In multichannel mode, the receive event occurs at serial edge E0+8*s+8, where s = `irq_sel[3:0]`. The transmit event uses s = `irq_sel[7:4]` in the same way.
- R5: In multichannel mode, a select greater than `last_chan` produces no event for that direction in that frame.
- R6: Each serial event gives exactly one system-clock pulse, one system cycle wide, on `irq_rx` or `irq_tx`. The pulse appears within four system cycles of the serial edge that carries the event.
- R7: A pulse sets the matching status bit (`stat_rx` or `stat_tx`), and the bit stays set until it is cleared.
- R8: A system cycle with `stat_wr` = 1 clears `stat_rx` if `stat_wdata[0]` = 1 and clears `stat_tx` if `stat_wdata[1]` = 1. A data bit of 0 leaves its status unchanged. A pulse in the same cycle as the clear wins, and the status stays 1.
- R9: A frame sync in the middle of a frame restarts slot counting at channel 0 from that edge. Events already raised stay raised, and events not yet reached are taken from the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock |
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| frame_sync | input | 1 | Frame start, sampled on sclk |
| multi_mode | input | 1 | 1 selects multichannel mode, 0 selects single-channel mode |
| last_chan | input | 4 | Highest channel number used in a multichannel frame |
| irq_sel | input | 8 | [3:0] receive event channel, [7:4] transmit event channel |
| stat_wr | input | 1 | Status write strobe (system clock) |
| stat_wdata | input | 2 | Write-one-to-clear data: [0] receive, [1] transmit |
| irq_rx | output | 1 | Receive interrupt pulse (system clock) |
| irq_tx | output | 1 | Transmit interrupt pulse (system clock) |
| stat_rx | output | 1 | Sticky receive status |
| stat_tx | output | 1 | Sticky transmit status |

## Verification
The hardest case to reach from the ports is a software clear that lands in the same system cycle as a fresh interrupt pulse. The bench waits until it sees `irq_rx` high at a falling system edge and drives the clear right away, so the write meets the pulse at the next rising edge. A mid-frame restart is also awkward to produce, because one receive event must fall before the second frame sync and the transmit event after it. The bench sets this up with directed selects and a frame sync issued 12 serial clocks into the frame. Random frames cover the timing of each slot across channel counts and selects.

// File: rtl/tdm_irq_pkg.sv
package tdm_irq_pkg;
  localparam int WORD_BITS = 8;
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int N_DIR     = 2;
  localparam int DIR_RX    = 0;
  localparam int DIR_TX    = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } trk_state_e;
endpackage

// File: rtl/tdm_rst_sync.sv
module tdm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker
  import tdm_irq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_sync,
  input  logic            multi_mode,
  input  logic [CH_W-1:0] last_chan,
  output logic [CH_W-1:0] slot_chan,
  output logic            word_first,
  output logic            word_last
);
  localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(WORD_BITS - 1);

  trk_state_e      state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [CH_W-1:0]  eff_last;
  logic             upd_en;

  // single-channel mode treats the frame as one word
  assign eff_last = multi_mode ? last_chan : '0;
  assign upd_en   = frame_sync | (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    chan_d  = chan_q;
    if (frame_sync) begin
      state_d = ST_RUN;
      bit_d   = BIT_TOP;
      chan_d  = '0;
    end else if (state_q == ST_RUN) begin
      if (bit_q == '0) begin
        bit_d = BIT_TOP;
        if (chan_q >= eff_last) begin
          state_d = ST_IDLE;
          chan_d  = '0;
        end else begin
          chan_d = chan_q + 1'b1;
        end
      end else begin
        bit_d = bit_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= BIT_TOP;
      chan_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      chan_q  <= chan_d;
    end
  end

  assign slot_chan  = chan_q;
  assign word_first = (state_q == ST_RUN) && (bit_q == BIT_TOP);
  assign word_last  = (state_q == ST_RUN) && (bit_q == '0);
endmodule

// File: rtl/tdm_irq_event.sv
module tdm_irq_event #(
  parameter int CH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            multi_mode,
  input  logic [CH_W-1:0] sel,
  input  logic [CH_W-1:0] last_chan,
  input  logic [CH_W-1:0] slot_chan,
  input  logic            word_first,
  input  logic            word_last,
  output logic            toggle
);
  logic hit;
  logic tog_q, tog_d;

  always_comb begin
    if (multi_mode) hit = word_last && (slot_chan == sel) && (sel <= last_chan);
    else            hit = word_first && (slot_chan == '0);
    tog_d = tog_q ^ hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tog_q <= 1'b0;
    else if (hit) tog_q <= tog_d;
  end

  assign toggle = tog_q;
endmodule

// File: rtl/tdm_pulse_sync.sv
module tdm_pulse_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_in,
  input  logic clr,
  output logic pulse,
  output logic status
);
  logic [2:0] sync_q;
  logic       stat_q, stat_d;
  logic       stat_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b000;
    else        sync_q <= {sync_q[1:0], tog_in};
  end

  assign pulse = sync_q[2] ^ sync_q[1];

  always_comb begin
    stat_en = pulse | clr;
    stat_d  = pulse;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign status = stat_q;
endmodule

// File: rtl/tdm_irq_gen.sv
module tdm_irq_gen
  import tdm_irq_pkg::*;
#(
  parameter int CH_W = 4
) (
  input  logic                  sclk,
  input  logic                  sys_clk,
  input  logic                  rst_n,
  input  logic                  frame_sync,
  input  logic                  multi_mode,
  input  logic [CH_W-1:0]       last_chan,
  input  logic [N_DIR*CH_W-1:0] irq_sel,
  input  logic                  stat_wr,
  input  logic [N_DIR-1:0]      stat_wdata,
  output logic                  irq_rx,
  output logic                  irq_tx,
  output logic                  stat_rx,
  output logic                  stat_tx
);
  logic             ser_rst_n;
  logic             sys_rst_n;
  logic [CH_W-1:0]  slot_chan;
  logic             word_first;
  logic             word_last;
  logic [N_DIR-1:0] tog;
  logic [N_DIR-1:0] irq_v;
  logic [N_DIR-1:0] stat_v;

  tdm_rst_sync i_ser_rst (.clk(sclk),    .arst_n(rst_n), .srst_n(ser_rst_n));
  tdm_rst_sync i_sys_rst (.clk(sys_clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  tdm_slot_tracker #(.CH_W(CH_W)) i_tracker (
    .clk        (sclk),
    .rst_n      (ser_rst_n),
    .frame_sync (frame_sync),
    .multi_mode (multi_mode),
    .last_chan  (last_chan),
    .slot_chan  (slot_chan),
    .word_first (word_first),
    .word_last  (word_last)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tdm_irq_event #(.CH_W(CH_W)) i_event (
      .clk        (sclk),
      .rst_n      (ser_rst_n),
      .multi_mode (multi_mode),
      .sel        (irq_sel[d*CH_W +: CH_W]),
      .last_chan  (last_chan),
      .slot_chan  (slot_chan),
      .word_first (word_first),
      .word_last  (word_last),
      .toggle     (tog[d])
    );

    tdm_pulse_sync i_sync (
      .clk    (sys_clk),
      .rst_n  (sys_rst_n),
      .tog_in (tog[d]),
      .clr    (stat_wr & stat_wdata[d]),
      .pulse  (irq_v[d]),
      .status (stat_v[d])
    );
  end

  assign irq_rx  = irq_v[DIR_RX];
  assign irq_tx  = irq_v[DIR_TX];
  assign stat_rx = stat_v[DIR_RX];
  assign stat_tx = stat_v[DIR_TX];
endmodule

// File: rtl/tdm_irq_gen_chk.sv
module tdm_irq_gen_chk #(
  parameter int CH_W = 4
) (
  input logic              sclk,
  input logic              sys_clk,
  input logic              ser_rst_n,
  input logic              sys_rst_n,
  input logic              multi_mode,
  input logic [CH_W-1:0]   last_chan,
  input logic [2*CH_W-1:0] irq_sel,
  input logic              stat_wr,
  input logic [1:0]        stat_wdata,
  input logic [1:0]        tog,
  input logic [1:0]        irq,
  input logic [1:0]        stat
);
  for (genvar d = 0; d < 2; d++) begin : g_chk
    // R5: a toggle flip in multichannel mode implies the select was in range
    p_sel_range_r5: assert property (@(posedge sclk) disable iff (!ser_rst_n)
      (!$stable(tog[d]) && $past(multi_mode)) |->
        ($past(irq_sel[d*CH_W +: CH_W]) <= $past(last_chan)));

    p_irq_one_cycle_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      irq[d] |=> !irq[d]);

    p_stat_set_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      irq[d] |=> stat[d]);

    p_stat_hold_r7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (stat[d] && !(stat_wr && stat_wdata[d])) |=> stat[d]);

    p_stat_clear_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
      (stat_wr && stat_wdata[d] && !irq[d]) |=> !stat[d]);
  end
endmodule

bind tdm_irq_gen tdm_irq_gen_chk #(.CH_W(CH_W)) i_chk (
  .sclk       (sclk),
  .sys_clk    (sys_clk),
  .ser_rst_n  (ser_rst_n),
  .sys_rst_n  (sys_rst_n),
  .multi_mode (multi_mode),
  .last_chan  (last_chan),
  .irq_sel    (irq_sel),
  .stat_wr    (stat_wr),
  .stat_wdata (stat_wdata),
  .tog        (tog),
  .irq        (irq_v),
  .stat       (stat_v)
);

// File: tb/test_tdm_irq_gen.sv
`timescale 1ns/1ps
module test_tdm_irq_gen;
  logic       sclk, sys_clk, rst_n;
  logic       frame_sync, multi_mode, stat_wr;
  logic [3:0] last_chan;
  logic [7:0] irq_sel;
  logic [1:0] stat_wdata;
  logic       irq_rx, irq_tx, stat_rx, stat_tx;

  int n_chk = 0;
  int n_fail = 0;
  int sclk_n = 0;
  int rx_cnt = 0, tx_cnt = 0, rx_at = -1, tx_at = -1, wide = 0;
  logic rx_prev = 1'b0, tx_prev = 1'b0;
  bit done = 0;

  tdm_irq_gen i_tdm_irq_gen (
    .sclk(sclk), .sys_clk(sys_clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .multi_mode(multi_mode), .last_chan(last_chan), .irq_sel(irq_sel),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
    .stat_rx(stat_rx), .stat_tx(stat_tx));

  initial begin sys_clk = 1'b0; forever #2 sys_clk = ~sys_clk; end
  initial begin sclk = 1'b0; #1; forever #10 sclk = ~sclk; end

  always @(posedge sclk) sclk_n <= sclk_n + 1;

  // pulse monitor, sampled on the falling system edge
  always @(negedge sys_clk) begin
    if (irq_rx) begin rx_cnt++; rx_at = sclk_n; end
    if (irq_tx) begin tx_cnt++; tx_at = sclk_n; end
    if ((irq_rx && rx_prev) || (irq_tx && tx_prev)) wide++;
    rx_prev = irq_rx;
    tx_prev = irq_tx;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic int exp_cnt(input bit m, input int last, input int sel);
    return (!m || sel <= last) ? 1 : 0;
  endfunction

  function automatic int exp_edge(input bit m, input int e0, input int sel);
    return m ? e0 + 8 * sel + 8 : e0 + 1;
  endfunction

  task automatic pulse_fs(output int e0);
    @(negedge sclk); frame_sync = 1'b1;
    @(negedge sclk); frame_sync = 1'b0;
    e0 = sclk_n;
  endtask

  task automatic run_frame(input bit m, input int last, input int srx, input int stx,
                           input string req);
    int e0, rc0, tc0;
    multi_mode = m; last_chan = 4'(last); irq_sel = {4'(stx), 4'(srx)};
    rc0 = rx_cnt; tc0 = tx_cnt;
    pulse_fs(e0);
    repeat (8 * (m ? last + 1 : 1) + 10) @(negedge sclk);
    check(rx_cnt - rc0 == exp_cnt(m, last, srx), {req, " rx count"}, rx_cnt - rc0, exp_cnt(m, last, srx));
    check(tx_cnt - tc0 == exp_cnt(m, last, stx), {req, " tx count"}, tx_cnt - tc0, exp_cnt(m, last, stx));
    if (exp_cnt(m, last, srx) == 1)
      check(rx_at == exp_edge(m, e0, srx), {req, " rx edge"}, rx_at, exp_edge(m, e0, srx));
    if (exp_cnt(m, last, stx) == 1)
      check(tx_at == exp_edge(m, e0, stx), {req, " tx edge"}, tx_at, exp_edge(m, e0, stx));
  endtask

  task automatic write_stat(input logic [1:0] d);
    @(negedge sys_clk); stat_wr = 1'b1; stat_wdata = d;
    @(negedge sys_clk); stat_wr = 1'b0; stat_wdata = 2'b00;
  endtask

  initial begin
    #600000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int e0, e1, rc0, tc0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; frame_sync = 1'b0; multi_mode = 1'b0; last_chan = 4'd0;
    irq_sel = 8'h00; stat_wr = 1'b0; stat_wdata = 2'b00;
    repeat (3) @(negedge sclk);
    // R1: reset state
    check({irq_rx, irq_tx, stat_rx, stat_tx} == 4'b0, "R1 in reset", {irq_rx, irq_tx, stat_rx, stat_tx}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge sclk);
    check({irq_rx, irq_tx, stat_rx, stat_tx} == 4'b0, "R1 after release", {irq_rx, irq_tx, stat_rx, stat_tx}, 0);

    // R3: single-channel mode ignores selects and channel count
    run_frame(1'b0, 0, 0, 0, "R3 single");
    run_frame(1'b0, 5, 9, 3, "R3 single sel ignored");
    // R7: status set after the pulse
    check(stat_rx && stat_tx, "R7 status set", {stat_tx, stat_rx}, 3);
    // R8: writing zero leaves status alone
    write_stat(2'b00);
    check(stat_rx && stat_tx, "R8 zero write", {stat_tx, stat_rx}, 3);
    write_stat(2'b01);
    check(!stat_rx && stat_tx, "R8 clear rx only", {stat_tx, stat_rx}, 2);
    write_stat(2'b10);
    check(!stat_rx && !stat_tx, "R8 clear tx", {stat_tx, stat_rx}, 0);

    // R4/R2: directed multichannel slots, first and last channel
    run_frame(1'b1, 3, 0, 3, "R4 multi first/last");
    run_frame(1'b1, 15, 15, 7, "R2 full sixteen slots");
    // R5: select beyond the channel count
    run_frame(1'b1, 2, 5, 2, "R5 rx out of range");
    run_frame(1'b1, 0, 0, 1, "R5 tx out of range");
    // R2: no event without a new frame sync
    rc0 = rx_cnt; tc0 = tx_cnt;
    repeat (200) @(negedge sclk);
    check(rx_cnt == rc0 && tx_cnt == tc0, "R2 idle after frame", rx_cnt - rc0 + tx_cnt - tc0, 0);

    // R9: restart in mid frame
    multi_mode = 1'b1; last_chan = 4'd3; irq_sel = {4'd2, 4'd0};
    rc0 = rx_cnt; tc0 = tx_cnt;
    pulse_fs(e0);
    repeat (10) @(negedge sclk);
    pulse_fs(e1);
    repeat (50) @(negedge sclk);
    check(rx_cnt - rc0 == 2, "R9 rx count", rx_cnt - rc0, 2);
    check(rx_at == e1 + 8, "R9 rx edge", rx_at, e1 + 8);
    check(tx_cnt - tc0 == 1, "R9 tx count", tx_cnt - tc0, 1);
    check(tx_at == e1 + 24, "R9 tx edge", tx_at, e1 + 24);

    // R8: clear colliding with a pulse, set wins
    write_stat(2'b11);
    multi_mode = 1'b0;
    pulse_fs(e0);
    for (int k = 0; k < 40 && !irq_rx; k++) @(negedge sys_clk);
    check(irq_rx, "R8 collision pulse seen", irq_rx, 1);
    stat_wr = 1'b1; stat_wdata = 2'b01;
    @(negedge sys_clk); stat_wr = 1'b0; stat_wdata = 2'b00;
    check(stat_rx, "R8 set beats clear", stat_rx, 1);
    repeat (20) @(negedge sclk);

    // R4/R5: random frames
    for (int i = 0; i < 30; i++) begin
      int l, a, b;
      l = int'($urandom_range(15, 0));
      a = int'($urandom_range(15, 0));
      b = int'($urandom_range(15, 0));
      run_frame(($urandom_range(3, 0) != 0), l, a, b, "R4 random");
    end

    // R6: every pulse exactly one system cycle wide
    check(wide == 0, "R6 pulse width", wide, 0);
    done = 1;
    finish_run();
  end
endmodule